// File: doc/BRIEF.md
# Synchronous Burst Flash Read Interface

This block is the device-side bus front end of a NOR-style flash memory that reads in synchronous bursts. A read starts on the first clock edge at which the chip is selected and the address-valid strobe is low. After a programmable number of latency cycles, the block drives one 16-bit word per clock onto the data bus. A WAIT output marks which cycles carry valid data, and its active level can be configured. In array mode the burst address steps through a wrap window or runs on linearly. In status, identifier and query modes a single word is repeated for the whole burst.

Writes take effect when the first of the two write enables (chip select or write strobe) rises. The address and data seen on the last cycle before that edge are used. A minimal command set is provided: read-mode selection, a two-write sequence that loads the configuration word, and a two-write sequence that stores one word into the small internal array. The bus is tri-stated through output-enable signals. This happens under output disable, under standby (chip deselected), and while the active-low reset is held.

Top module: `sbf_bus_if`

## Requirements
- R1: While rst_n is low, dq_oe and wait_oe are 0. After reset the block is in array-read mode with configuration word 16'h2407: synchronous, latency code 4, WAIT active high, continuous burst.
- R2: An address is captured on the first rising clock edge at which ce_n=0, adv_n=0 and we_n=1. If adv_n stays low, no further capture happens. Raising adv_n and lowering it again aborts the running burst and starts a new one at the new address.
- R3: The latency L is taken from configuration bits [13:11]. Codes 2 to 7 give L = code+1; the reserved codes 0 and 1 give L = 8. The first word is on dq_o after the L-th rising edge following the capture edge. Until then WAIT is at its asserted level.
- R4: In array mode, words follow one per clock from the captured address. Configuration bits [2:0] select the pattern: 001 wraps within an aligned 4-word block, 010 within 8, 011 within 16. Any other code increments linearly.
- R5: Non-array modes repeat one word on every clock: status gives 16'h0080, identifier gives 16'h00A5 at even addresses and 16'h7E21 at odd addresses, and query gives 16'h0051 plus the address. WAIT shows this word as valid for exactly the burst length, then goes to its asserted level. With a continuous burst code, the word stays valid indefinitely.
- R6: In synchronous mode (configuration bit 15 = 0), WAIT is deasserted only while valid data is on dq_o. Configuration bit 10 is the asserted level of WAIT, and the deasserted level is its complement.
- R7: A write needs ce_n=0, we_n=0 and oe_n=1. The write is committed when ce_n or we_n rises, whichever comes first, using the address and data of the last cycle before that edge. Low byte codes: FF selects array mode, 70 status, 90 identifier, 98 query. Code 40 makes the next write store its data into the array. Code 60 makes the next write's data the configuration word.
- R8: During a write cycle, wait_oe is 1, WAIT is held at its deasserted level, and dq_oe is 0.
- R9: When oe_n=1 (outside a write), dq_oe and wait_oe are 0. When ce_n=1, both are 0 whatever the level of oe_n.
- R10: In asynchronous mode (configuration bit 15 = 1), dq_o shows the word at the address pins registered one clock later, and WAIT stays deasserted.
- R11: Asserting rst_n in the middle of operation returns the block to array mode and the default configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr_i | input | AW | Word address |
| dq_i | input | 16 | Data bus, inbound half |
| dq_o | output | 16 | Data bus, outbound half |
| dq_oe | output | 1 | Drive enable for dq_o (0 = high impedance) |
| wait_o | output | 1 | WAIT level |
| wait_oe | output | 1 | Drive enable for wait_o (0 = high impedance) |

## Verification
The embedded properties watch several things on every cycle. They check that no data is flagged valid on the edge right after a capture. They check that the latency count keeps falling while ADV# is held low, so no recapture happens. They check that the linear burst address steps by one, that non-array reads hold their address, and that a write is never committed on two cycles in a row. Other behaviour shows only in the bench's directed scenarios, which compare port values against a bench-side model of the array. These include the exact cycle of the first word for each latency code, wrap-boundary sequences, the non-array burst cut-off, the first-edge choice between the two write enables, tri-state under disable, standby and reset, and the asynchronous mode.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_ID     = 2'd2,
        MD_QUERY  = 2'd3
    } rd_mode_e;

    typedef struct packed {
        logic       async_m;
        logic [2:0] lat;
        logic       wpol;
        logic [2:0] bl;
    } cfg_t;

    localparam logic [7:0]  CMD_ARRAY   = 8'hFF;
    localparam logic [7:0]  CMD_STATUS  = 8'h70;
    localparam logic [7:0]  CMD_ID      = 8'h90;
    localparam logic [7:0]  CMD_QUERY   = 8'h98;
    localparam logic [7:0]  CMD_PROG    = 8'h40;
    localparam logic [7:0]  CMD_CFG     = 8'h60;
    localparam logic [15:0] CFG_DEFAULT = 16'h2407;
    localparam logic [15:0] STATUS_WORD = 16'h0080;
    localparam logic [3:0]  LAT_OFS     = 4'd1;
    localparam logic [3:0]  LAT_MAX     = 4'd8;

    function automatic cfg_t cfg_unpack(input logic [15:0] w);
        cfg_t c;
        c.async_m = w[15];
        c.lat     = w[13:11];
        c.wpol    = w[10];
        c.bl      = w[2:0];
        return c;
    endfunction

    function automatic logic [3:0] lat_cycles(input logic [2:0] code);
        return (code < 3'd2) ? LAT_MAX : ({1'b0, code} + LAT_OFS);
    endfunction

    function automatic logic [4:0] burst_len(input logic [2:0] code);
        case (code)
            3'd1:    return 5'd4;
            3'd2:    return 5'd8;
            3'd3:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/sbf_word_mem.sv
module sbf_word_mem #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sbf_cmd_cfg.sv
module sbf_cmd_cfg
    import sbf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr_i,
    input  logic [15:0]   dq_i,
    output rd_mode_e      mode_o,
    output cfg_t          cfg_o,
    output logic          mem_we,
    output logic [AW-1:0] mem_wa,
    output logic [15:0]   mem_wd
);
    typedef struct packed {
        rd_mode_e      mode;
        cfg_t          cfg;
        logic          arm_prog;
        logic          arm_cfg;
        logic          wr_act;
        logic [AW-1:0] wa;
        logic [15:0]   wd;
    } state_t;

    state_t q, n;
    logic   wr_now;
    logic   commit;

    always_comb begin
        n      = q;
        wr_now = !ce_n && !we_n && oe_n;
        commit = q.wr_act && !wr_now;
        mem_we = 1'b0;
        n.wr_act = wr_now;
        if (wr_now) begin
            n.wa = addr_i;
            n.wd = dq_i;
        end
        if (commit) begin
            if (q.arm_prog) begin
                mem_we     = 1'b1;
                n.arm_prog = 1'b0;
            end else if (q.arm_cfg) begin
                n.cfg     = cfg_unpack(q.wd);
                n.arm_cfg = 1'b0;
            end else begin
                case (q.wd[7:0])
                    CMD_ARRAY:  n.mode     = MD_ARRAY;
                    CMD_STATUS: n.mode     = MD_STATUS;
                    CMD_ID:     n.mode     = MD_ID;
                    CMD_QUERY:  n.mode     = MD_QUERY;
                    CMD_PROG:   n.arm_prog = 1'b1;
                    CMD_CFG:    n.arm_cfg  = 1'b1;
                    default:    n.mode     = q.mode;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode     <= MD_ARRAY;
            q.cfg      <= cfg_unpack(CFG_DEFAULT);
            q.arm_prog <= 1'b0;
            q.arm_cfg  <= 1'b0;
            q.wr_act   <= 1'b0;
            q.wa       <= '0;
            q.wd       <= '0;
        end else begin
            q <= n;
        end
    end

    assign mode_o = q.mode;
    assign cfg_o  = q.cfg;
    assign mem_wa = q.wa;
    assign mem_wd = q.wd;

    // R7: a write is committed once per enable cycle
    a_r7_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/sbf_burst_seq.sv
module sbf_burst_seq
    import sbf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          adv_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr_i,
    input  logic          async_i,
    input  logic [2:0]    lat_code_i,
    input  logic [2:0]    bl_code_i,
    input  logic          nonarray_i,
    input  logic [15:0]   rd_word_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [15:0]   dout_o,
    output logic          valid_o
);
    typedef struct packed {
        logic          active;
        logic          adv_hold;
        logic [3:0]    lat;
        logic [AW-1:0] addr;
        logic [4:0]    beats;
        logic          valid;
        logic [15:0]   dout;
    } state_t;

    state_t        q, n;
    logic          cap;
    logic [4:0]    blen;
    logic          cont;
    logic [AW-1:0] wmask;

    always_comb begin
        n     = q;
        blen  = burst_len(bl_code_i);
        cont  = (blen == 5'd0);
        wmask = cont ? '1 : AW'(blen - 5'd1);
        cap   = sel && !adv_n && we_n && !q.adv_hold;
        n.adv_hold = sel && !adv_n;
        if (async_i) begin
            n.active = 1'b0;
            n.valid  = 1'b1;
            n.dout   = rd_word_i;
        end else if (!sel || !we_n) begin
            n.active = 1'b0;
            n.valid  = 1'b0;
        end else if (cap) begin
            n.active = 1'b1;
            n.addr   = addr_i;
            n.lat    = lat_cycles(lat_code_i) - 4'd1;
            n.beats  = '0;
            n.valid  = 1'b0;
        end else if (q.active) begin
            if (q.lat != 4'd0) begin
                n.lat   = q.lat - 4'd1;
                n.valid = 1'b0;
            end else begin
                n.dout = rd_word_i;
                if (nonarray_i) begin
                    n.valid = cont || (q.beats < blen);
                    if (q.beats != 5'd31) begin
                        n.beats = q.beats + 5'd1;
                    end
                end else begin
                    n.valid = 1'b1;
                    n.addr  = (q.addr & ~wmask) | ((q.addr + AW'(1)) & wmask);
                end
            end
        end else begin
            n.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign rd_addr_o = async_i ? addr_i : q.addr;
    assign dout_o    = q.dout;
    assign valid_o   = q.valid;

    // R3: nothing is valid on the edge right after a capture
    a_r3_no_early_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !async_i) |=> !q.valid);

    // R2: a held ADV# does not reload the latency count
    a_r2_no_recapture: assert property (@(posedge clk) disable iff (!rst_n)
        (q.adv_hold && !adv_n && sel && we_n && !async_i && q.active && q.lat != 4'd0)
        |=> q.lat == $past(q.lat) - 4'd1);

    // R4: a linear array burst steps the address by one
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_i && sel && we_n && !cap && q.active && q.lat == 4'd0
         && !nonarray_i && cont) |=> q.addr == $past(q.addr) + AW'(1));

    // R5: a non-array burst keeps its address
    a_r5_nonarray_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_i && sel && we_n && !cap && q.active && nonarray_i)
        |=> $stable(q.addr));

endmodule

// File: rtl/sbf_bus_if.sv
module sbf_bus_if
    import sbf_pkg::*;
#(
    parameter int          AW       = 6,
    parameter logic [15:0] MFR_ID   = 16'h00A5,
    parameter logic [15:0] DEV_ID   = 16'h7E21,
    parameter logic [15:0] QRY_BASE = 16'h0051
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_i,
    input  logic [15:0]   dq_i,
    output logic [15:0]   dq_o,
    output logic          dq_oe,
    output logic          wait_o,
    output logic          wait_oe
);
    rd_mode_e      mode;
    cfg_t          cfg;
    logic          mem_we;
    logic [AW-1:0] mem_wa;
    logic [15:0]   mem_wd;
    logic [AW-1:0] rd_addr;
    logic [15:0]   mem_rd;
    logic [15:0]   rd_word;
    logic          valid;
    logic          wait_asserted;

    sbf_cmd_cfg #(.AW(AW)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .addr_i (addr_i),
        .dq_i   (dq_i),
        .mode_o (mode),
        .cfg_o  (cfg),
        .mem_we (mem_we),
        .mem_wa (mem_wa),
        .mem_wd (mem_wd)
    );

    sbf_word_mem #(.AW(AW), .DW(16)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_wa),
        .wdata (mem_wd),
        .raddr (rd_addr),
        .rdata (mem_rd)
    );

    always_comb begin
        case (mode)
            MD_STATUS: rd_word = STATUS_WORD;
            MD_ID:     rd_word = rd_addr[0] ? DEV_ID : MFR_ID;
            MD_QUERY:  rd_word = QRY_BASE + 16'(rd_addr);
            default:   rd_word = mem_rd;
        endcase
    end

    sbf_burst_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (!ce_n),
        .adv_n      (adv_n),
        .we_n       (we_n),
        .addr_i     (addr_i),
        .async_i    (cfg.async_m),
        .lat_code_i (cfg.lat),
        .bl_code_i  (cfg.bl),
        .nonarray_i (mode != MD_ARRAY),
        .rd_word_i  (rd_word),
        .rd_addr_o  (rd_addr),
        .dout_o     (dq_o),
        .valid_o    (valid)
    );

    assign wait_asserted = we_n && !cfg.async_m && !valid;
    assign wait_o  = wait_asserted ? cfg.wpol : !cfg.wpol;
    assign dq_oe   = rst_n && !ce_n && !oe_n && we_n;
    assign wait_oe = rst_n && !ce_n && (!oe_n || !we_n);

endmodule

// File: tb/tb_sbf_bus_if.sv
module tb_sbf_bus_if;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, we_n, adv_n;
    logic [AW-1:0] addr_i;
    logic [15:0]   dq_i;
    logic [15:0]   dq_o;
    logic          dq_oe, wait_o, wait_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [15:0] model [64];

    sbf_bus_if #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .adv_n(adv_n), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe(dq_oe), .wait_o(wait_o), .wait_oe(wait_oe)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] bnext(input logic [5:0] a, input int blen);
        logic [5:0] m;
        if (blen == 0) return a + 6'd1;
        m = 6'(blen - 1);
        return (a & ~m) | ((a + 6'd1) & m);
    endfunction

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; adv_n = 1; addr_i = a; dq_i = d;
        @(negedge clk);
        we_n = 1;
        @(negedge clk);
        ce_n = 1;
    endtask

    task automatic set_cfg(input logic [15:0] v);
        bus_write(0, 16'h0060);
        bus_write(0, v);
    endtask

    task automatic rd_begin(input logic [5:0] a, input bit keep);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; adv_n = 0; addr_i = a;
        @(negedge clk);
        if (!keep) adv_n = 1;
    endtask

    task automatic rd_follow(input string req, input logic [5:0] a, input int lat,
                             input int blen, input logic pol, input bit na,
                             input logic [15:0] naw, input int beats);
        logic [5:0] ea = a;
        for (int k = 1; k <= lat + beats; k++) begin
            @(negedge clk);
            if (k < lat) begin
                chk({req, " wait during latency"}, {15'b0, wait_o}, {15'b0, pol});
            end else if (na) begin
                if (blen == 0 || (k - lat) < blen) begin
                    chk({req, " repeated word"}, dq_o, naw);
                    chk({req, " wait valid"}, {15'b0, wait_o}, {15'b0, !pol});
                end else begin
                    chk({req, " wait after burst"}, {15'b0, wait_o}, {15'b0, pol});
                end
            end else begin
                chk({req, " burst word"}, dq_o, model[ea]);
                chk({req, " wait valid"}, {15'b0, wait_o}, {15'b0, !pol});
                ea = bnext(ea, blen);
            end
        end
    endtask

    task automatic rd_end();
        @(negedge clk);
        ce_n = 1; oe_n = 1; adv_n = 1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        ce_n = 0; oe_n = 0;
        #1;
        chk("R1 dq_oe in reset", {15'b0, dq_oe}, 16'h0);
        chk("R1 wait_oe in reset", {15'b0, wait_oe}, 16'h0);
        @(negedge clk);
        ce_n = 1; oe_n = 1; rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) begin
            model[i] = 16'h3C00 + 16'(i) * 16'h0111;
            bus_write(6'(i), 16'h0040);
            bus_write(6'(i), model[i]);
        end
    endtask

    task automatic t_default_read();  // R1 R3 R4: default latency 5, continuous
        rd_begin(2, 0);
        rd_follow("R1", 2, 5, 0, 1'b1, 0, 0, 8);
        rd_end();
    endtask

    task automatic t_wrap_modes();
        set_cfg(16'h1401);  // R4 wrap 4, R3 L=3
        rd_begin(6, 0); rd_follow("R4", 6, 3, 4, 1'b1, 0, 0, 6); rd_end();
        set_cfg(16'h3802);  // R4 wrap 8, L=8, R6 WAIT active low
        rd_begin(13, 0); rd_follow("R6", 13, 8, 8, 1'b0, 0, 0, 6); rd_end();
        set_cfg(16'h0007);  // R3 reserved code -> 8
        rd_begin(1, 0); rd_follow("R3", 1, 8, 0, 1'b0, 0, 0, 3); rd_end();
        set_cfg(16'h1403);  // R4 wrap 16
        rd_begin(14, 0); rd_follow("R4", 14, 3, 16, 1'b1, 0, 0, 4); rd_end();
    endtask

    task automatic t_nonarray();
        set_cfg(16'h1401);
        bus_write(0, 16'h0070);
        rd_begin(5, 0); rd_follow("R5 status", 5, 3, 4, 1'b1, 1, 16'h0080, 6); rd_end();
        bus_write(0, 16'h0090);
        rd_begin(1, 0); rd_follow("R5 id", 1, 3, 4, 1'b1, 1, 16'h7E21, 5); rd_end();
        rd_begin(2, 0); rd_follow("R5 id", 2, 3, 4, 1'b1, 1, 16'h00A5, 5); rd_end();
        bus_write(0, 16'h0098);
        set_cfg(16'h1407);
        rd_begin(3, 0); rd_follow("R5 query", 3, 3, 0, 1'b1, 1, 16'h0054, 20); rd_end();
        bus_write(0, 16'h00FF);
        rd_begin(9, 0); rd_follow("R7 array again", 9, 3, 0, 1'b1, 0, 0, 3); rd_end();
    endtask

    task automatic t_adv();
        set_cfg(16'h2407);
        rd_begin(3, 1); rd_follow("R2 held adv", 3, 5, 0, 1'b1, 0, 0, 5); rd_end();
        rd_begin(4, 0); rd_follow("R2 first", 4, 5, 0, 1'b1, 0, 0, 2);
        rd_begin(10, 0); rd_follow("R2 abort", 10, 5, 0, 1'b1, 0, 0, 3); rd_end();
    endtask

    task automatic t_write_edges();
        bus_write(7, 16'h0040);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr_i = 7; dq_i = 16'h1234;
        @(negedge clk); we_n = 1; addr_i = 8; dq_i = 16'hDEAD;
        @(negedge clk); ce_n = 1;
        model[7] = 16'h1234;
        bus_write(9, 16'h0040);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr_i = 9; dq_i = 16'h4321;
        @(negedge clk); ce_n = 1; addr_i = 10; dq_i = 16'hBEEF;
        @(negedge clk); we_n = 1;
        model[9] = 16'h4321;
        rd_begin(7, 0); rd_follow("R7 first edge", 7, 5, 0, 1'b1, 0, 0, 4); rd_end();
    endtask

    task automatic t_write_wait();
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr_i = 0; dq_i = 16'h00FF;
        #1;
        chk("R8 wait_oe", {15'b0, wait_oe}, 16'h1);
        chk("R8 wait level", {15'b0, wait_o}, 16'h0);
        chk("R8 dq_oe", {15'b0, dq_oe}, 16'h0);
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic t_hiz();
        rd_begin(2, 0); rd_follow("R9 pre", 2, 5, 0, 1'b1, 0, 0, 2);
        @(negedge clk); oe_n = 1; #1;
        chk("R9 dq_oe off", {15'b0, dq_oe}, 16'h0);
        chk("R9 wait_oe off", {15'b0, wait_oe}, 16'h0);
        @(negedge clk); oe_n = 0; ce_n = 1; #1;
        chk("R9 standby dq_oe", {15'b0, dq_oe}, 16'h0);
        chk("R9 standby wait_oe", {15'b0, wait_oe}, 16'h0);
        rd_end();
    endtask

    task automatic t_async();
        set_cfg(16'h8400);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; adv_n = 1; addr_i = 5;
        @(negedge clk);
        chk("R10 async word", dq_o, model[5]);
        chk("R10 async wait", {15'b0, wait_o}, 16'h0);
        addr_i = 11;
        @(negedge clk);
        chk("R10 async word", dq_o, model[11]);
        rd_end();
        set_cfg(16'h2407);
    endtask

    task automatic t_midreset();
        set_cfg(16'h1401);
        bus_write(0, 16'h0070);
        @(negedge clk); ce_n = 0; oe_n = 0; #1;
        rst_n = 0; #1;
        chk("R11 dq_oe in reset", {15'b0, dq_oe}, 16'h0);
        @(negedge clk); @(negedge clk);
        rst_n = 1; ce_n = 1; oe_n = 1;
        rd_begin(2, 0); rd_follow("R11 defaults", 2, 5, 0, 1'b1, 0, 0, 3); rd_end();
    endtask

    initial begin
        rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; adv_n = 1; addr_i = '0; dq_i = '0;
        t_reset();
        t_fill();
        t_default_read();
        t_wrap_modes();
        t_nonarray();
        t_adv();
        t_write_edges();
        t_write_wait();
        t_hiz();
        t_async();
        t_midreset();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule